// File: doc/BRIEF.md
# Symbol-Matrix Memory Word Protector

This block guards a 32-bit memory word against clustered upsets. A 32-bit word is cut into eight 4-bit symbols. The symbols form a grid of two rows and four columns. Two kinds of check information are stored with the data:

- **Horizontal checks:** each row carries two 5-bit arithmetic sums, each taken over a pair of symbols.
- **Vertical checks:** each column carries a 4-bit XOR of its two symbols.

On a write the block returns the 68-bit codeword to store. On a read it takes a stored codeword and returns the repaired data word with two status flags. The read uses the same encoder as the write to recompute the checks from the data it gets back. A small comparator then forms the syndromes from the recomputed and stored checks.

The block has one request port with a valid/ready handshake. A single `op_write` bit picks the operation. The result of every accepted request comes out of one output register. That register holds its value while the consumer stalls.

Top module: `dmc_ecc`

## Requirements
- R1: Symbol s (s = 0..7) is data bits [4s+3:4s]. It sits in row s/4 and column s%4.
- R2: Horizontal check h = 2r+p (r = row 0..1, p = 0..1) occupies bits [5h+4:5h] of the 20-bit horizontal field. It is the unsigned 5-bit sum of the symbols in columns p and p+2 of row r.
- R3: Vertical check c (c = 0..3) occupies bits [4c+3:4c] of the 16-bit vertical field. It is the XOR of the column-c symbols of rows 0 and 1.
- R4: A write accepted at a clock edge produces a result after that edge with out_is_write=1, corrected_data equal to the written word, and both flags 0. The codeword is ordered {vertical[15:0], horizontal[19:0], data[31:0]} (bits 67:52, 51:32, 31:0).
- R5: A read of a codeword whose checks match its data returns the data unchanged with error_detected=0 and error_corrected=0.
- R6: A read in which any run of 1 to 5 adjacent data bits (bits 31:0 of the codeword) is inverted returns the original data, with error_detected=1 and error_corrected=1.
- R7: A read in which one bit of the check region (bits 67:32) is inverted returns the stored data unchanged, with error_detected=1 and error_corrected=0.
- R8: in_ready is high whenever out_valid is low or out_ready is high. While out_valid is high and out_ready is low, all outputs hold their values.
- R9: out_valid is 0 during and right after reset. It rises on the edge after any accepted request.
- R10: error_corrected is never 1 while error_detected is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| op_write | input | 1 | 1 = encode wr_data, 0 = check rd_codeword |
| wr_data | input | 32 | Word to encode |
| rd_codeword | input | 68 | Stored codeword to check |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_is_write | output | 1 | Result belongs to a write |
| codeword_out | output | 68 | Encoded codeword (write) or codeword as received (read) |
| corrected_data | output | 32 | Written word or repaired read data |
| error_detected | output | 1 | Some syndrome was nonzero |
| error_corrected | output | 1 | At least one data symbol was flipped |

## Verification
Every result appears in the output register one clock edge after its request is accepted, whether the request is a write or a read. While the consumer stalls, the result stays in that register and does not change. The driver records each expected result in a queue at the point of acceptance, which is the negative edge at which in_valid and in_ready are both seen high. The monitor pops the queue only on a negative edge at which out_valid and out_ready are both high, so each comparison lands on the cycle in which that result is handed over. Because out_ready is varied at random, results are also checked after they have been held through stalls.

// File: rtl/dmc_ecc_pkg.sv
package dmc_ecc_pkg;
  localparam int SYM_W  = 4;
  localparam int ROWS   = 2;
  localparam int COLS   = 4;
  localparam int PAIRS  = COLS / 2;
  localparam int SUM_W  = SYM_W + 1;
  localparam int DATA_W = SYM_W * ROWS * COLS;
  localparam int HOR_W  = ROWS * PAIRS * SUM_W;
  localparam int VER_W  = COLS * SYM_W;
  localparam int CW_W   = VER_W + HOR_W + DATA_W;
endpackage

// File: rtl/dmc_encoder.sv
module dmc_encoder #(
  parameter int SYM_W = 4,
  parameter int ROWS  = 2,
  parameter int COLS  = 4
) (
  input  logic [SYM_W*ROWS*COLS-1:0]             data,
  output logic [ROWS*(COLS/2)*(SYM_W+1)-1:0]     hor,
  output logic [COLS*SYM_W-1:0]                  ver
);
  localparam int PAIRS = COLS / 2;
  localparam int SUM_W = SYM_W + 1;

  // arithmetic pair sums per row
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
      localparam int SA = r * COLS + p;
      localparam int SB = r * COLS + p + PAIRS;
      localparam int H  = r * PAIRS + p;
      assign hor[H*SUM_W +: SUM_W] = {1'b0, data[SA*SYM_W +: SYM_W]}
                                   + {1'b0, data[SB*SYM_W +: SYM_W]};
    end
  end

  // column XOR across all rows
  for (genvar c = 0; c < COLS; c++) begin : g_col
    always_comb begin
      ver[c*SYM_W +: SYM_W] = '0;
      for (int r = 0; r < ROWS; r++) begin
        ver[c*SYM_W +: SYM_W] = ver[c*SYM_W +: SYM_W] ^ data[(r*COLS+c)*SYM_W +: SYM_W];
      end
    end
  end
endmodule

// File: rtl/dmc_syndrome.sv
module dmc_syndrome #(
  parameter int SYM_W = 4,
  parameter int ROWS  = 2,
  parameter int COLS  = 4
) (
  input  logic [ROWS*(COLS/2)*(SYM_W+1)-1:0] hor_calc,
  input  logic [ROWS*(COLS/2)*(SYM_W+1)-1:0] hor_stored,
  input  logic [COLS*SYM_W-1:0]              ver_calc,
  input  logic [COLS*SYM_W-1:0]              ver_stored,
  output logic [ROWS*(COLS/2)-1:0]           hflag,
  output logic [COLS*SYM_W-1:0]              vsyn,
  output logic [COLS-1:0]                    vflag
);
  localparam int NH    = ROWS * (COLS / 2);
  localparam int SUM_W = SYM_W + 1;

  for (genvar g = 0; g < NH; g++) begin : g_hsyn
    logic signed [SUM_W:0] diff;
    assign diff = $signed({1'b0, hor_calc[g*SUM_W +: SUM_W]})
                - $signed({1'b0, hor_stored[g*SUM_W +: SUM_W]});
    assign hflag[g] = (diff != '0);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_vsyn
    assign vsyn[c*SYM_W +: SYM_W] = ver_calc[c*SYM_W +: SYM_W] ^ ver_stored[c*SYM_W +: SYM_W];
    assign vflag[c] = |vsyn[c*SYM_W +: SYM_W];
  end
endmodule

// File: rtl/dmc_corrector.sv
module dmc_corrector #(
  parameter int SYM_W = 4,
  parameter int ROWS  = 2,
  parameter int COLS  = 4
) (
  input  logic [SYM_W*ROWS*COLS-1:0] data_in,
  input  logic [ROWS*(COLS/2)-1:0]   hflag,
  input  logic [COLS*SYM_W-1:0]      vsyn,
  input  logic [COLS-1:0]            vflag,
  output logic [SYM_W*ROWS*COLS-1:0] data_out,
  output logic                       any_flip
);
  localparam int PAIRS = COLS / 2;
  localparam int NSYM  = ROWS * COLS;

  logic [NSYM-1:0] flip;

  // a symbol is repaired when its column XOR and its row pair sum both disagree
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int S = r * COLS + c;
      localparam int G = r * PAIRS + (c % PAIRS);
      assign flip[S] = vflag[c] & hflag[G];
      assign data_out[S*SYM_W +: SYM_W] = data_in[S*SYM_W +: SYM_W]
                                        ^ (flip[S] ? vsyn[c*SYM_W +: SYM_W] : {SYM_W{1'b0}});
    end
  end

  assign any_flip = |flip;
endmodule

// File: rtl/dmc_ecc.sv
module dmc_ecc
  import dmc_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              op_write,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CW_W-1:0]   rd_codeword,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_is_write,
  output logic [CW_W-1:0]   codeword_out,
  output logic [DATA_W-1:0] corrected_data,
  output logic              error_detected,
  output logic              error_corrected
);
  localparam int NH = ROWS * PAIRS;

  logic [DATA_W-1:0] enc_in;
  logic [HOR_W-1:0]  hor_calc;
  logic [VER_W-1:0]  ver_calc;
  logic [HOR_W-1:0]  hor_stored;
  logic [VER_W-1:0]  ver_stored;
  logic [NH-1:0]     hflag;
  logic [VER_W-1:0]  vsyn;
  logic [COLS-1:0]   vflag;
  logic [DATA_W-1:0] fixed_data;
  logic              any_flip;
  logic              fire;

  assign hor_stored = rd_codeword[DATA_W +: HOR_W];
  assign ver_stored = rd_codeword[DATA_W+HOR_W +: VER_W];

  // one encoder serves both operations
  assign enc_in = op_write ? wr_data : rd_codeword[DATA_W-1:0];

  dmc_encoder #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_enc (
    .data (enc_in),
    .hor  (hor_calc),
    .ver  (ver_calc)
  );

  dmc_syndrome #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_syn (
    .hor_calc   (hor_calc),
    .hor_stored (hor_stored),
    .ver_calc   (ver_calc),
    .ver_stored (ver_stored),
    .hflag      (hflag),
    .vsyn       (vsyn),
    .vflag      (vflag)
  );

  dmc_corrector #(.SYM_W(SYM_W), .ROWS(ROWS), .COLS(COLS)) u_cor (
    .data_in  (rd_codeword[DATA_W-1:0]),
    .hflag    (hflag),
    .vsyn     (vsyn),
    .vflag    (vflag),
    .data_out (fixed_data),
    .any_flip (any_flip)
  );

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      out_is_write <= op_write;
      if (op_write) begin
        codeword_out    <= {ver_calc, hor_calc, wr_data};
        corrected_data  <= wr_data;
        error_detected  <= 1'b0;
        error_corrected <= 1'b0;
      end else begin
        codeword_out    <= rd_codeword;
        corrected_data  <= fixed_data;
        error_detected  <= (|hflag) || (|vflag);
        error_corrected <= any_flip;
      end
    end
  end
endmodule

// File: rtl/dmc_ecc_chk.sv
module dmc_ecc_chk
  import dmc_ecc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              op_write,
  input logic [DATA_W-1:0] wr_data,
  input logic [CW_W-1:0]   rd_codeword,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_is_write,
  input logic [CW_W-1:0]   codeword_out,
  input logic [DATA_W-1:0] corrected_data,
  input logic              error_detected,
  input logic              error_corrected
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(corrected_data)
      && $stable(codeword_out) && $stable(error_detected) && $stable(error_corrected));

  // R8
  idle_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);

  // R9
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R10
  flag_order_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && error_corrected |-> error_detected);

  // R4
  write_echo_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_ready && op_write) |->
      out_is_write && codeword_out[DATA_W-1:0] == $past(wr_data) && !error_detected);

  // R5
  clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid && in_ready && !op_write) && !error_detected |->
      corrected_data == $past(rd_codeword[DATA_W-1:0]));
endmodule

bind dmc_ecc dmc_ecc_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .op_write(op_write), .wr_data(wr_data), .rd_codeword(rd_codeword),
  .out_valid(out_valid), .out_ready(out_ready), .out_is_write(out_is_write),
  .codeword_out(codeword_out), .corrected_data(corrected_data),
  .error_detected(error_detected), .error_corrected(error_corrected)
);

// File: tb/dmc_ecc_tb.sv
module dmc_ecc_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic        op_write;
  logic [31:0] wr_data;
  logic [67:0] rd_codeword;
  logic        out_valid;
  logic        out_ready;
  logic        out_is_write;
  logic [67:0] codeword_out;
  logic [31:0] corrected_data;
  logic        error_detected;
  logic        error_corrected;

  typedef struct {
    logic        is_wr;
    logic        chk_cw;
    logic [67:0] cw;
    logic [31:0] data;
    logic        det;
    logic        cor;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit stall_en = 0;

  always #2.5 clk = ~clk;

  dmc_ecc u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .op_write(op_write), .wr_data(wr_data), .rd_codeword(rd_codeword),
    .out_valid(out_valid), .out_ready(out_ready), .out_is_write(out_is_write),
    .codeword_out(codeword_out), .corrected_data(corrected_data),
    .error_detected(error_detected), .error_corrected(error_corrected)
  );

  // reference encoder built from R1..R3
  function automatic logic [67:0] ref_enc(input logic [31:0] d);
    logic [19:0] h;
    logic [15:0] v;
    for (int r = 0; r < 2; r++)
      for (int p = 0; p < 2; p++)
        h[(2*r+p)*5 +: 5] = 5'(d[(4*r+p)*4 +: 4]) + 5'(d[(4*r+p+2)*4 +: 4]);
    for (int c = 0; c < 4; c++)
      v[c*4 +: 4] = d[c*4 +: 4] ^ d[(c+4)*4 +: 4];
    return {v, h, d};
  endfunction

  task automatic check(input string req, input string what, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic wr, input logic [31:0] wd, input logic [67:0] cw, input exp_t e);
    @(negedge clk);
    in_valid = 1'b1; op_write = wr; wr_data = wd; rd_codeword = cw;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(e);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] d);
    exp_t e;
    e.is_wr = 1; e.chk_cw = 1; e.cw = ref_enc(d); e.data = d; e.det = 0; e.cor = 0;
    e.req = "R4";
    send(1'b1, d, '0, e);
  endtask

  task automatic do_read(input logic [67:0] cw, input logic [31:0] d, input logic det,
                         input logic cor, input string req);
    exp_t e;
    e.is_wr = 0; e.chk_cw = 1; e.cw = cw; e.data = d; e.det = det; e.cor = cor; e.req = req;
    send(1'b0, 32'h0, cw, e);
  endtask

  // monitor: compare at handover cycles
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check("R9", "unexpected result", 68'(1), 68'(0));
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(e.req, "is_write", 68'(out_is_write), 68'(e.is_wr));
          if (e.chk_cw) check(e.req, "codeword", codeword_out, e.cw);
          check(e.req, "data", 68'(corrected_data), 68'(e.data));
          check(e.req, "detected", 68'(error_detected), 68'(e.det));
          check(e.req, "corrected", 68'(error_corrected), 68'(e.cor));
          check("R10", "flag order", 68'(error_corrected & ~error_detected), 68'(0));
        end
      end
    end
  end

  // consumer backpressure
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1 out_ready = stall_en ? ($urandom_range(3) != 0) : 1'b1;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [67:0] cw;
    rst = 1'b1; in_valid = 1'b0; op_write = 1'b0; wr_data = '0; rd_codeword = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R9", "out_valid in reset", 68'(out_valid), 68'(0));
    #1 rst = 1'b0;
    @(negedge clk);
    check("R9", "out_valid after reset", 68'(out_valid), 68'(0));
    check("R8", "in_ready idle", 68'(in_ready), 68'(1));

    // R1 R2 R3 R4: encoding on distinct patterns
    do_write(32'h0000_0000);
    do_write(32'hFFFF_FFFF);
    do_write(32'h7654_3210);
    do_write(32'hA5A5_5A5A);
    for (int i = 0; i < 8; i++) do_write($urandom);

    // R5: clean reads
    for (int i = 0; i < 8; i++) begin
      d = $urandom;
      do_read(ref_enc(d), d, 1'b0, 1'b0, "R5");
    end

    stall_en = 1;
    // R6: every adjacent burst of 1..5 bits in the data region
    for (int len = 1; len <= 5; len++) begin
      for (int st = 0; st + len <= 32; st++) begin
        d = $urandom;
        cw = ref_enc(d);
        for (int b = st; b < st + len; b++) cw[b] = ~cw[b];
        do_read(cw, d, 1'b1, 1'b1, "R6");
      end
    end

    // R7: single upset in any check bit
    for (int b = 32; b < 68; b++) begin
      d = $urandom;
      cw = ref_enc(d);
      cw[b] = ~cw[b];
      do_read(cw, d, 1'b1, 1'b0, "R7");
    end

    // R8: mixed traffic under stalls
    for (int i = 0; i < 10; i++) begin
      d = $urandom;
      do_write(d);
      do_read(ref_enc(d), d, 1'b0, 1'b0, "R8");
    end

    stall_en = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check("R9", "idle after drain", 68'(out_valid), 68'(0));
    finish_run();
  end
endmodule